// File: doc/BRIEF.md
# Interrupt Line Trigger Capture

This block sits in front of a pair of cascaded 8-input interrupt controllers: a primary unit and a secondary unit. It watches sixteen raw interrupt lines. Lines 0 to 7 belong to the primary unit and lines 8 to 15 to the secondary unit. For each line it produces per-cycle strobes that tell the controller's request register to set or clear that line's bit. It also outputs the synchronized level of every line. Priority resolution and vector generation are done elsewhere.

Each unit has an 8-bit trigger-mode register. A 1 selects level triggering for that line and a 0 selects edge triggering. Software reaches both registers through a single byte-wide port, selected by a one-bit unit address. Some lines are fixed to edge mode: write masks drop any level setting aimed at them.

The raw lines are synchronized, then compared with their value from the previous cycle to detect rising and falling transitions. While a unit has not finished initialization, every strobe for that unit's lines is held low. The configuration port and the status outputs are plain signals with no handshake, because nothing streams through the block.

Top module: `irq_trigger_capture`

## Requirements
- R1: After reset both trigger-mode registers read 0 (all lines edge-triggered), and no set or clear strobe is active.
- R2: A write with `cfg_sel`=0 stores `cfg_wdata & 8'hF8` in the primary register, so lines 0, 1 and 2 stay edge-triggered. `cfg_rdata` shows the selected register in the same cycle.
- R3: A write with `cfg_sel`=1 stores `cfg_wdata & 8'hDE` in the secondary register, so lines 8 and 13 stay edge-triggered.
- R4: Line n is controlled by register n/8, bit n mod 8. Its strobes appear only on bit n of `req_set` and `req_clr`.
- R5: A rising transition on an edge-mode line raises `req_set[n]` for exactly one cycle, sampled after the second rising clock edge that follows the line change.
- R6: A falling transition on an edge-mode line produces no clear strobe, so the latched request is kept.
- R7: A level-mode line raises `req_set[n]` on every cycle its synchronized level is high.
- R8: A falling transition on a level-mode line raises `req_clr[n]` for exactly one cycle, at the same latency as R5.
- R9: While `ctrl_ready[c]` is 0, no strobe is raised for any line of unit c. Lines of the other unit are unaffected. Transitions seen during that time are lost, but a level-mode line that is still high sets its request again once the unit is ready.
- R10: `line_level[n]` follows the raw line two clock edges later.
- R11: A raw pulse one cycle wide yields one set strobe. On a level-mode line it is followed in the next cycle by one clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_raw | input | 16 | Asynchronous raw interrupt lines |
| ctrl_ready | input | 2 | Per-unit "initialization complete" flags (bit 0 primary) |
| cfg_we | input | 1 | Trigger-mode register write enable |
| cfg_sel | input | 1 | Unit select for the register port (0 primary, 1 secondary) |
| cfg_wdata | input | 8 | Write data, bit k = line k of the unit, 1 = level |
| cfg_rdata | output | 8 | Contents of the selected trigger-mode register |
| req_set | output | 16 | Per-line request-set strobes |
| req_clr | output | 16 | Per-line request-clear strobes |
| line_level | output | 16 | Synchronized line levels |

## Verification
All 256 byte values are written to both units and read back. This separates the two write masks from each other and from an unmasked store. Every one of the sixteen lines is then raised, held and dropped, once with its mode bit cleared and once with it requested as level. The cycle-exact strobe pattern distinguishes edge from level behaviour and shows which lines are forced to edge mode, and checking the other fifteen bits catches wrong line mapping. The remaining patterns cover the rest. A mixed-readiness pattern checks that gating applies per unit and that a held level-mode request returns once the unit is ready. A one-cycle pulse checks that a short event still yields both strobes in order.

// File: rtl/irq_trigger_capture_pkg.sv
package irq_trigger_capture_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  // Lines that are never allowed to be level-triggered: 0, 1, 2, 8, 13.
  localparam logic [15:0] DEFAULT_EDGE_ONLY = 16'h2107;

  function automatic int unsigned sel_width(input int unsigned units);
    return (units > 1) ? $clog2(units) : 1;
  endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign level_o = stage_q[STAGES-1];
  assign prev_o  = prev_q;

endmodule

// File: rtl/irq_trig_cfg.sv
module irq_trig_cfg #(
  parameter int unsigned UNITS    = 2,
  parameter int unsigned PER_UNIT = 8,
  parameter int unsigned SEL_W    = 1,
  parameter logic [UNITS*PER_UNIT-1:0] EDGE_ONLY = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [PER_UNIT-1:0]       wdata_i,
  output logic [PER_UNIT-1:0]       rdata_o,
  output logic [UNITS*PER_UNIT-1:0] mode_o
);

  logic [PER_UNIT-1:0] mode_q [UNITS];

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    localparam logic [PER_UNIT-1:0] WMASK = ~EDGE_ONLY[u*PER_UNIT +: PER_UNIT];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[u] <= '0;
      end else if (we_i && (32'(sel_i) == u)) begin
        mode_q[u] <= wdata_i & WMASK;
      end
    end
    assign mode_o[u*PER_UNIT +: PER_UNIT] = mode_q[u];
  end

  always_comb begin
    rdata_o = '0;
    for (int u = 0; u < UNITS; u++) begin
      if (32'(sel_i) == u) rdata_o = mode_q[u];
    end
  end

endmodule

// File: rtl/irq_req_event.sv
module irq_req_event #(
  parameter int unsigned UNITS    = 2,
  parameter int unsigned PER_UNIT = 8
) (
  input  logic [UNITS-1:0]          ready_i,
  input  logic [UNITS*PER_UNIT-1:0] mode_i,
  input  logic [UNITS*PER_UNIT-1:0] level_i,
  input  logic [UNITS*PER_UNIT-1:0] prev_i,
  output logic [UNITS*PER_UNIT-1:0] set_o,
  output logic [UNITS*PER_UNIT-1:0] clr_o
);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic [PER_UNIT-1:0] lvl, prv, mde, rise, fall, gate;
    assign lvl  = level_i[u*PER_UNIT +: PER_UNIT];
    assign prv  = prev_i[u*PER_UNIT +: PER_UNIT];
    assign mde  = mode_i[u*PER_UNIT +: PER_UNIT];
    assign gate = {PER_UNIT{ready_i[u]}};
    assign rise = lvl & ~prv;
    assign fall = ~lvl & prv;
    assign set_o[u*PER_UNIT +: PER_UNIT] = gate & (rise | (mde & lvl));
    assign clr_o[u*PER_UNIT +: PER_UNIT] = gate & fall & mde;
  end

endmodule

// File: rtl/irq_trigger_capture.sv
module irq_trigger_capture
  import irq_trigger_capture_pkg::*;
#(
  parameter int unsigned UNITS       = 2,
  parameter int unsigned PER_UNIT    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [UNITS*PER_UNIT-1:0] EDGE_ONLY = DEFAULT_EDGE_ONLY,
  localparam int unsigned LINES = UNITS * PER_UNIT,
  localparam int unsigned SEL_W = sel_width(UNITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINES-1:0]    irq_raw,
  input  logic [UNITS-1:0]    ctrl_ready,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [PER_UNIT-1:0] cfg_wdata,
  output logic [PER_UNIT-1:0] cfg_rdata,
  output logic [LINES-1:0]    req_set,
  output logic [LINES-1:0]    req_clr,
  output logic [LINES-1:0]    line_level
);

  logic [LINES-1:0] lvl_mode;
  logic [LINES-1:0] prev_level;

  irq_line_sync #(
    .WIDTH  (LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (irq_raw),
    .level_o (line_level),
    .prev_o  (prev_level)
  );

  irq_trig_cfg #(
    .UNITS     (UNITS),
    .PER_UNIT  (PER_UNIT),
    .SEL_W     (SEL_W),
    .EDGE_ONLY (EDGE_ONLY)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .sel_i   (cfg_sel),
    .wdata_i (cfg_wdata),
    .rdata_o (cfg_rdata),
    .mode_o  (lvl_mode)
  );

  irq_req_event #(
    .UNITS    (UNITS),
    .PER_UNIT (PER_UNIT)
  ) u_evt (
    .ready_i (ctrl_ready),
    .mode_i  (lvl_mode),
    .level_i (line_level),
    .prev_i  (prev_level),
    .set_o   (req_set),
    .clr_o   (req_clr)
  );

endmodule

// File: rtl/irq_trigger_capture_chk.sv
module irq_trigger_capture_chk #(
  parameter int unsigned UNITS    = 2,
  parameter int unsigned PER_UNIT = 8,
  parameter int unsigned SEL_W    = 1,
  parameter logic [UNITS*PER_UNIT-1:0] EDGE_ONLY = '0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [UNITS-1:0]          ctrl_ready,
  input logic [SEL_W-1:0]          cfg_sel,
  input logic [PER_UNIT-1:0]       cfg_rdata,
  input logic [UNITS*PER_UNIT-1:0] req_set,
  input logic [UNITS*PER_UNIT-1:0] req_clr,
  input logic [UNITS*PER_UNIT-1:0] line_level,
  input logic [UNITS*PER_UNIT-1:0] lvl_mode
);

  localparam int unsigned LINES = UNITS * PER_UNIT;

  AST_CFG_FORCED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_sel) < UNITS) |->
      ((cfg_rdata & EDGE_ONLY[32'(cfg_sel)*PER_UNIT +: PER_UNIT]) == '0)); // R2

  AST_MODE_FORCED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode & EDGE_ONLY) == '0); // R3

  for (genvar n = 0; n < LINES; n++) begin : g_line
    localparam int unsigned U = n / PER_UNIT;

    AST_GATED_BY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_set[n] || req_clr[n]) |-> ctrl_ready[U]); // R9

    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_set[n] && req_clr[n])); // R4

    AST_EDGE_SINGLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_set[n] && !lvl_mode[n]) |=> (!req_set[n] || lvl_mode[n])); // R5

    AST_EDGE_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      req_clr[n] |-> lvl_mode[n]); // R6

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_ready[U] && lvl_mode[n] && line_level[n]) |-> req_set[n]); // R7

    AST_CLR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      req_clr[n] |-> (!line_level[n] && $past(line_level[n]))); // R8
  end

endmodule

bind irq_trigger_capture irq_trigger_capture_chk #(
  .UNITS     (UNITS),
  .PER_UNIT  (PER_UNIT),
  .SEL_W     (SEL_W),
  .EDGE_ONLY (EDGE_ONLY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_ready (ctrl_ready),
  .cfg_sel    (cfg_sel),
  .cfg_rdata  (cfg_rdata),
  .req_set    (req_set),
  .req_clr    (req_clr),
  .line_level (line_level),
  .lvl_mode   (lvl_mode)
);

// File: tb/irq_trigger_capture_test.sv
`timescale 1ns/1ps
module irq_trigger_capture_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_raw;
  logic [1:0]  ctrl_ready;
  logic        cfg_we;
  logic [0:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [15:0] req_set, req_clr, line_level;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_trigger_capture uut (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .ctrl_ready(ctrl_ready),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_set(req_set), .req_clr(req_clr),
    .line_level(line_level)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit forced_edge(input int n);
    return (n == 0) || (n == 1) || (n == 2) || (n == 8) || (n == 13);
  endfunction

  task automatic cfg_write(input int unit, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'(unit); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Raise, hold and drop one line; check strobes cycle by cycle (R4 R5 R6 R7 R8 R10).
  task automatic line_cycle(input int n, input bit want_level);
    logic [15:0] bitn;
    bit eff;
    bitn = 16'h1 << n;
    eff  = want_level && !forced_edge(n);
    cfg_write(n / 8, want_level ? 8'(1 << (n % 8)) : 8'h00);
    cfg_write(1 - n / 8, 8'h00);
    irq_raw = bitn;                                    // driven at a negedge
    @(negedge clk);
    chk("R10 not yet synced", line_level, 16'h0);
    chk("R5 no early set", req_set, 16'h0);
    @(negedge clk);
    chk("R10 level after two edges", line_level, bitn);
    chk("R4 R5 set on rise", req_set, bitn);
    chk("R4 no clear on rise", req_clr, 16'h0);
    @(negedge clk);
    chk(eff ? "R7 level keeps setting" : "R5 single set", req_set, eff ? bitn : 16'h0);
    irq_raw = 16'h0;
    @(negedge clk);
    chk("R7 R5 held before fall seen", req_set, eff ? bitn : 16'h0);
    @(negedge clk);
    chk(eff ? "R8 clear on fall" : "R6 no clear on edge fall", req_clr, eff ? bitn : 16'h0);
    chk("R7 R5 no set after fall", req_set, 16'h0);
    @(negedge clk);
    chk("R8 single clear", req_clr, 16'h0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_raw = '0; ctrl_ready = 2'b11;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    cfg_sel = 1'b0; #1;
    chk("R1 primary reset", {8'h0, cfg_rdata}, 16'h0);
    cfg_sel = 1'b1; #1;
    chk("R1 secondary reset", {8'h0, cfg_rdata}, 16'h0);
    chk("R1 no set", req_set, 16'h0);
    chk("R1 no clear", req_clr, 16'h0);

    // R2 R3: exhaustive write masks
    for (int v = 0; v < 256; v++) begin
      cfg_write(0, 8'(v));
      cfg_sel = 1'b0; #1;
      chk("R2 primary mask", {8'h0, cfg_rdata}, 16'(v & 8'hF8));
      cfg_write(1, 8'(v));
      cfg_sel = 1'b1; #1;
      chk("R3 secondary mask", {8'h0, cfg_rdata}, 16'(v & 8'hDE));
      cfg_sel = 1'b0; #1;
      chk("R2 primary untouched by secondary write", {8'h0, cfg_rdata}, 16'(v & 8'hF8));
    end

    // Every line in both modes
    for (int n = 0; n < 16; n++) begin
      line_cycle(n, 1'b0);
      line_cycle(n, 1'b1);
    end

    // R9: secondary not ready, line 5 (edge) and line 12 (level)
    cfg_write(0, 8'h00);
    cfg_write(1, 8'h10);
    ctrl_ready = 2'b01;
    irq_raw = 16'h1020;
    @(negedge clk); @(negedge clk);
    chk("R9 only ready unit strobes", req_set, 16'h0020);
    @(negedge clk);
    chk("R9 blocked level line", req_set, 16'h0);
    ctrl_ready = 2'b11; #1;
    chk("R9 level request returns when ready", req_set, 16'h1000);
    irq_raw = 16'h0;
    @(negedge clk);
    ctrl_ready = 2'b01;
    @(negedge clk);
    chk("R9 clear blocked while not ready", req_clr, 16'h0);
    ctrl_ready = 2'b11;
    repeat (3) @(negedge clk);

    // R11: one-cycle pulse on line 3, level mode
    cfg_write(0, 8'h08);
    irq_raw = 16'h0008;
    @(negedge clk);
    irq_raw = 16'h0;
    @(negedge clk);
    chk("R11 pulse sets", req_set, 16'h0008);
    @(negedge clk);
    chk("R11 pulse clears", req_clr, 16'h0008);
    chk("R11 no second set", req_set, 16'h0);
    @(negedge clk);
    chk("R11 quiet after pulse", req_set | req_clr, 16'h0);

    // R11: one-cycle pulse on line 9, edge mode
    cfg_write(1, 8'h00);
    irq_raw = 16'h0200;
    @(negedge clk);
    irq_raw = 16'h0;
    @(negedge clk);
    chk("R11 edge pulse sets", req_set, 16'h0200);
    @(negedge clk);
    chk("R11 edge pulse no clear", req_clr | req_set, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule